// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Sequencer

This block is the single-master bus interface for read transfers on a bus whose low address lines double as the 16-bit data lines. The internal side raises a request with a 20-bit address, a size flag (byte or 16-bit word) and a memory-or-I/O flag. The sequencer then runs a fixed run of phases on the external pins, called T1, T2, T3 and T4. It returns the read value with a one-clock done pulse.

In T1 the full address is driven and a latch-enable strobe lets external logic capture it. From T2 onward the shared pins are released and an active-low read strobe is asserted. The device answers during T3, and a ready input can stretch T3 with wait states. The value is captured as T3 ends and is presented in T4. A high-byte enable and address bit 0 select the byte lanes. A byte from the high lane is returned right-aligned.

Top module: `mbus_rd_seq`

## Requirements
- R1: A request seen high while idle starts T1 on the next clock. With ready high, T2, T3 and T4 follow on consecutive clocks, so `done_o` is high in the fourth cycle of the transfer and in no earlier one.
- R2: `ale_o` and `bus_oe_o` are high in T1 only. During T1, `bus_out_o` carries the 20-bit address, with bit 0 set as described in R5.
- R3: `mio_o` equals the request's I/O flag (0 = memory, 1 = I/O) in every phase from T1 through T4, and is 0 when idle.
- R4: `rd_n_o` is low in T2, T3 and in every wait state, and high in T4 and when idle. `bus_oe_o` is low from T2 through T4.
- R5: The lane select from T1 through T4 is as follows. For a word request, `hbe_n_o`=0 and address bit 0 is driven as 0, whatever the request's bit 0. For a byte request with bit 0 = 0, `hbe_n_o`=1 and bit 0 = 0. For a byte request with bit 0 = 1, `hbe_n_o`=0 and bit 0 = 1. `hbe_n_o` is 1 when idle.
- R6: The returned value depends on the request. A word request returns `bus_in_i[15:0]`. A low-lane byte returns `{8'h00, bus_in_i[7:0]}`. A high-lane byte returns `{8'h00, bus_in_i[15:8]}`. The bus is sampled at the clock edge that ends the last T3 or wait cycle, so a bus change during T4 has no effect.
- R7: If `rdy_i` is low at the edge ending T3, a wait state with the T3 pin levels follows. Waits repeat until `rdy_i` is seen high, and then T4 follows. Each wait adds exactly one clock.
- R8: `done_o` is high for exactly one clock, in T4. `rdata_o` then holds the captured value and keeps it after the transfer.
- R9: A request raised while a transfer is in progress, and dropped before the sequencer returns to idle, is ignored: no new T1 follows.
- R10: A synchronous active-high reset returns the sequencer to idle with `ale_o` low, `rd_n_o` high, `bus_oe_o` low and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Read request, sampled while idle |
| addr_i | input | 20 | Read address |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| io_i | input | 1 | 1 = I/O space, 0 = memory |
| rdata_o | output | 16 | Returned read value |
| done_o | output | 1 | One-clock completion pulse |
| bus_out_o | output | 20 | Address driven onto the shared pins |
| bus_oe_o | output | 1 | Drive enable for the shared pins |
| bus_in_i | input | 16 | Data from the shared pins |
| ale_o | output | 1 | Address latch enable strobe |
| mio_o | output | 1 | Memory (0) or I/O (1) select |
| hbe_n_o | output | 1 | High-byte enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rdy_i | input | 1 | Ready; low stretches T3 |

## Verification
The assertions assume that `rdy_i` and `bus_in_i` are steady around the rising edge. They also assume that the device eventually raises ready, so the wait loop ends. The bench changes every input only on the falling clock edge. It holds `rdy_i` low for a fixed count of wait cycles and then raises it, and it raises requests only when the sequencer is idle, except in the deliberate busy-request case for R9.

// File: rtl/mbus_rd_pkg.sv
package mbus_rd_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = DATA_W / 2;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic                io;
        logic                word;
        logic [DATA_W-1:0]   data;
    } seq_s;
endpackage

// File: rtl/mbus_lane_sel.sv
module mbus_lane_sel (
    input  logic word_i,
    input  logic a0_i,
    output logic hbe_n_o,
    output logic a0_o
);
    always_comb begin
        if (word_i) begin
            hbe_n_o = 1'b0;
            a0_o    = 1'b0;
        end else begin
            hbe_n_o = ~a0_i;
            a0_o    = a0_i;
        end
    end
endmodule

// File: rtl/mbus_rd_align.sv
module mbus_rd_align #(
    parameter int DATA_W = 16
) (
    input  logic              word_i,
    input  logic              hi_lane_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int LANE_W = DATA_W / 2;

    always_comb begin
        if (word_i)
            data_o = bus_i;
        else if (hi_lane_i)
            data_o = {{LANE_W{1'b0}}, bus_i[DATA_W-1:LANE_W]};
        else
            data_o = {{LANE_W{1'b0}}, bus_i[LANE_W-1:0]};
    end
endmodule

// File: rtl/mbus_rd_seq.sv
module mbus_rd_seq
    import mbus_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_i,
    input  logic              io_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] bus_out_o,
    output logic              bus_oe_o,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic              ale_o,
    output logic              mio_o,
    output logic              hbe_n_o,
    output logic              rd_n_o,
    input  logic              rdy_i
);
    localparam seq_s SEQ_RST = '{phase: PH_IDLE, default: '0};

    seq_s q, d;
    logic lane_hbe_n;
    logic lane_a0;
    logic [DATA_W-1:0] aligned;
    logic active;

    mbus_lane_sel u_lane (
        .word_i (q.word),
        .a0_i   (q.addr[0]),
        .hbe_n_o(lane_hbe_n),
        .a0_o   (lane_a0)
    );

    mbus_rd_align #(.DATA_W(DATA_W)) u_align (
        .word_i   (q.word),
        .hi_lane_i(q.addr[0]),
        .bus_i    (bus_in_i),
        .data_o   (aligned)
    );

    always_comb begin
        d = q;
        case (q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    d.phase = PH_T1;
                    d.addr  = addr_i;
                    d.io    = io_i;
                    d.word  = word_i;
                end
            end
            PH_T1: d.phase = PH_T2;
            PH_T2: d.phase = PH_T3;
            PH_T3, PH_TW: begin
                if (rdy_i) begin
                    d.phase = PH_T4;
                    d.data  = aligned;
                end else begin
                    d.phase = PH_TW;
                end
            end
            PH_T4:   d.phase = PH_IDLE;
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= SEQ_RST;
        else     q <= d;
    end

    assign active    = (q.phase != PH_IDLE);
    assign ale_o     = (q.phase == PH_T1);
    assign bus_oe_o  = (q.phase == PH_T1);
    assign rd_n_o    = !((q.phase == PH_T2) || (q.phase == PH_T3) || (q.phase == PH_TW));
    assign done_o    = (q.phase == PH_T4);
    assign mio_o     = active & q.io;
    assign hbe_n_o   = active ? lane_hbe_n : 1'b1;
    assign bus_out_o = {q.addr[ADDR_W-1:1], lane_a0};
    assign rdata_o   = q.data;
endmodule

// File: rtl/mbus_rd_seq_chk.sv
module mbus_rd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        done_o,
    input logic [19:0] bus_out_o,
    input logic        bus_oe_o,
    input logic        ale_o,
    input logic        mio_o,
    input logic        hbe_n_o,
    input logic        rd_n_o,
    input logic        rdy_i
);
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale_o |=> !ale_o);

    p_ale_then_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        ale_o |=> (!rd_n_o && !bus_oe_o));

    p_no_drive_while_read_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !bus_oe_o);

    p_mio_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (!ale_o && (!rd_n_o || done_o)) |-> $stable(mio_o));

    p_lane_legal_r5: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> !(hbe_n_o && bus_out_o[0]));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o && !rdy_i) |=> (!rd_n_o && !done_o));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_strobe_off_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> rd_n_o);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!ale_o && rd_n_o && !bus_oe_o && !done_o));
endmodule

bind mbus_rd_seq mbus_rd_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .done_o   (done_o),
    .bus_out_o(bus_out_o),
    .bus_oe_o (bus_oe_o),
    .ale_o    (ale_o),
    .mio_o    (mio_o),
    .hbe_n_o  (hbe_n_o),
    .rd_n_o   (rd_n_o),
    .rdy_i    (rdy_i)
);

// File: tb/mbus_rd_seq_test.sv
`timescale 1ns/1ps
module mbus_rd_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic        word_i = 1'b0;
    logic        io_i = 1'b0;
    logic [15:0] rdata_o;
    logic        done_o;
    logic [19:0] bus_out_o;
    logic        bus_oe_o;
    logic [15:0] bus_in_i = '0;
    logic        ale_o;
    logic        mio_o;
    logic        hbe_n_o;
    logic        rd_n_o;
    logic        rdy_i = 1'b1;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    mbus_rd_seq uut (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .word_i(word_i),
        .io_i(io_i), .rdata_o(rdata_o), .done_o(done_o), .bus_out_o(bus_out_o),
        .bus_oe_o(bus_oe_o), .bus_in_i(bus_in_i), .ale_o(ale_o), .mio_o(mio_o),
        .hbe_n_o(hbe_n_o), .rd_n_o(rd_n_o), .rdy_i(rdy_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] want_data(input bit word, input bit a0, input logic [15:0] bus);
        if (word) return bus;
        if (a0) return {8'h00, bus[15:8]};
        return {8'h00, bus[7:0]};
    endfunction

    // monitor: pops the scoreboard whenever a transfer completes
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 32'(rdata_o), 32'hFFFF_FFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rdata_o == e, "R6 read data", 32'(rdata_o), 32'(e));
            end
        end
    end

    task automatic do_read(input logic [19:0] a, input bit io, input bit word,
                           input logic [15:0] bus, input int waits, input bit busy_req);
        logic [15:0] e;
        logic [19:0] aexp;
        bit hexp;
        e    = want_data(word, word ? 1'b0 : a[0], bus);
        aexp = word ? {a[19:1], 1'b0} : a;
        hexp = word ? 1'b0 : ~a[0];
        @(negedge clk);
        req_i = 1'b1; addr_i = a; io_i = io; word_i = word;
        bus_in_i = bus; rdy_i = (waits == 0);
        exp_q.push_back(e);
        @(negedge clk); // T1
        req_i = 1'b0;
        chk(ale_o == 1'b1, "R1/R2 ale in T1", 32'(ale_o), 32'd1);
        chk(bus_oe_o == 1'b1, "R2 drive in T1", 32'(bus_oe_o), 32'd1);
        chk(bus_out_o == aexp, "R2/R5 address", 32'(bus_out_o), 32'(aexp));
        chk(mio_o == io, "R3 mio in T1", 32'(mio_o), 32'(io));
        chk(hbe_n_o == hexp, "R5 hbe in T1", 32'(hbe_n_o), 32'(hexp));
        chk(rd_n_o == 1'b1, "R4 strobe off in T1", 32'(rd_n_o), 32'd1);
        @(negedge clk); // T2
        if (busy_req) req_i = 1'b1;
        chk(ale_o == 1'b0, "R2 ale low in T2", 32'(ale_o), 32'd0);
        chk(rd_n_o == 1'b0, "R4 strobe in T2", 32'(rd_n_o), 32'd0);
        chk(bus_oe_o == 1'b0, "R4 release in T2", 32'(bus_oe_o), 32'd0);
        chk(mio_o == io, "R3 mio in T2", 32'(mio_o), 32'(io));
        @(negedge clk); // T3
        chk(rd_n_o == 1'b0, "R4 strobe in T3", 32'(rd_n_o), 32'd0);
        chk(done_o == 1'b0, "R1 no early done", 32'(done_o), 32'd0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk); // wait state
            chk(rd_n_o == 1'b0 && done_o == 1'b0, "R7 wait state", 32'({rd_n_o, done_o}), 32'd0);
            chk(hbe_n_o == hexp, "R5 hbe in wait", 32'(hbe_n_o), 32'(hexp));
            if (w == waits - 1) rdy_i = 1'b1;
        end
        @(negedge clk); // T4
        chk(done_o == 1'b1, "R1/R7/R8 done in T4", 32'(done_o), 32'd1);
        chk(rd_n_o == 1'b1, "R4 strobe off in T4", 32'(rd_n_o), 32'd1);
        chk(bus_oe_o == 1'b0, "R4 no drive in T4", 32'(bus_oe_o), 32'd0);
        chk(mio_o == io, "R3 mio in T4", 32'(mio_o), 32'(io));
        bus_in_i = ~bus;
        req_i = 1'b0;
        @(negedge clk); // idle
        chk(done_o == 1'b0, "R8 done one clock", 32'(done_o), 32'd0);
        chk(rdata_o == e, "R6/R8 data held", 32'(rdata_o), 32'(e));
        chk(ale_o == 1'b0, "R9 no restart", 32'(ale_o), 32'd0);
        chk(mio_o == 1'b0 && hbe_n_o == 1'b1, "R3/R5 idle levels", 32'({mio_o, hbe_n_o}), 32'd1);
        if (busy_req) begin
            @(negedge clk);
            chk(ale_o == 1'b0 && rd_n_o == 1'b1, "R9 busy request ignored", 32'({ale_o, rd_n_o}), 32'd1);
        end
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ale_o == 1'b0 && rd_n_o == 1'b1 && bus_oe_o == 1'b0 && done_o == 1'b0,
            "R10 reset state", 32'({ale_o, rd_n_o, bus_oe_o, done_o}), 32'b0100);
        rst = 1'b0;
        @(negedge clk);
        chk(ale_o == 1'b0, "R10 idle after reset", 32'(ale_o), 32'd0);

        do_read(20'hABCD4, 1'b0, 1'b1, 16'h1234, 0, 1'b0);
        do_read(20'h00F10, 1'b1, 1'b0, 16'hBEEF, 0, 1'b0);
        do_read(20'h12345, 1'b0, 1'b0, 16'hBEEF, 2, 1'b0);
        do_read(20'hFFFFF, 1'b1, 1'b1, 16'h5AC3, 1, 1'b0);
        do_read(20'h80001, 1'b0, 1'b0, 16'h7E81, 3, 1'b1);
        do_read(20'h00000, 1'b0, 1'b1, 16'h0F0F, 0, 1'b1);

        // reset in the middle of a transfer
        @(negedge clk);
        req_i = 1'b1; addr_i = 20'h3; word_i = 1'b0; io_i = 1'b1; rdy_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(ale_o == 1'b0 && rd_n_o == 1'b1 && bus_oe_o == 1'b0 && done_o == 1'b0,
            "R10 mid-transfer reset", 32'({ale_o, rd_n_o, bus_oe_o, done_o}), 32'b0100);
        rst = 1'b0; rdy_i = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        chk(done_o == 1'b0, "R10 no done after reset", 32'(done_o), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule